// File: doc/BRIEF.md
# Receive Line Idle and Inactivity Supervisor

This block watches a serial receive line for the length of one receive operation. It raises an exception when the line goes idle, and another when too much time passes with nothing useful arriving. A controller starts the operation with a start pulse, and the two 8-bit timeout values are sampled on that pulse. It ends the operation with a stop pulse. Time is measured in slow ticks supplied from outside, about 106 ms each, so an 8-bit value spans up to about 27 s.

The first timer sets an idle-detect window. While the timer runs, an idle line is not reported. Monitoring for idle starts when the window runs out or when a flag is received, whichever comes first. Idle means a run of fifteen one bits taken on the bit strobe. The second timer totals the nonproductive time, meaning ticks during which no flag and no frame activity is present. It signals a timeout when that total reaches its programmed value. A timeout value of zero turns off the matching check. A new start pulse while an operation is in progress reloads both timers, which lets a chain of receive requests each carry its own values.

Top module: `rx_line_watchdog`

## Requirements
- R1: After reset, `idle_exc_o`, `idle_sts_o` and `nprod_exc_o` are 0.
- R2: An idle condition is 15 consecutive one bits sampled on cycles with `bit_stb_i` high. Any sampled 0 restarts the run. A run longer than 15 still counts as idle, because the count saturates.
- R3: A start pulse with a nonzero `idle_tmo_i` begins an idle-detect window of that many ticks. No idle exception is raised while the window is open. On the tick that closes the window, idle monitoring begins.
- R4: A `flag_stb_i` pulse while the idle-detect window is open closes the window and begins idle monitoring at once.
- R5: When `idle_tmo_i` is 0 at start, idle monitoring never begins in that operation, whether flags arrive or not.
- R6: While idle monitoring is on and the line is idle, `idle_exc_o` is high for exactly one cycle, starting the cycle after both hold. `idle_sts_o` rises at the same time and stays high until the next start pulse or reset. At most one idle exception is raised per operation.
- R7: The nonproductive timer counts only ticks with `frame_act_i` and `flag_stb_i` both low. Activity pauses the count without clearing it. On the cycle after the tick that completes `nprod_tmo_i` counted ticks, `nprod_exc_o` is high for one cycle, and this happens at most once per operation.
- R8: When `nprod_tmo_i` is 0 at start, `nprod_exc_o` never asserts in that operation.
- R9: A start pulse during an operation reloads both timers from the current inputs, restarts the ones run and clears `idle_sts_o`.
- R10: After a stop pulse, neither exception asserts until the next start. The stop pulse does not clear `idle_sts_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_start_i | input | 1 | Start (or chain) a receive operation; samples both timeout values |
| rx_stop_i | input | 1 | End the receive operation |
| bit_stb_i | input | 1 | Qualifies `bit_i` for one cycle |
| bit_i | input | 1 | Received line bit |
| flag_stb_i | input | 1 | Single-cycle pulse for each received flag |
| frame_act_i | input | 1 | High while a frame is being received |
| tick_i | input | 1 | Single-cycle slow time-base pulse |
| idle_tmo_i | input | 8 | Idle-detect window in ticks; 0 disables idle checking |
| nprod_tmo_i | input | 8 | Nonproductive time limit in ticks; 0 disables |
| idle_exc_o | output | 1 | One-cycle idle exception |
| idle_sts_o | output | 1 | Sticky idle status, cleared by start |
| nprod_exc_o | output | 1 | One-cycle nonproductive timeout exception |

## Verification
The properties assume that `tick_i`, `flag_stb_i` and `bit_stb_i` are single-cycle strobes, and that a start pulse takes priority over a stop pulse arriving in the same cycle. The properties also take the timeout inputs to matter only on the start cycle. The stimulus keeps to these assumptions. It changes every input on the falling edge, raises each strobe for exactly one clock, and never raises start and stop together. It changes the timeout inputs only together with a start pulse.

// File: rtl/rxw_pkg.sv
package rxw_pkg;

   // Default timer width and idle run length
   localparam int unsigned RXW_TMR_W    = 8;
   localparam int unsigned RXW_IDLE_RUN = 15;

   // Idle monitoring phase within one receive operation
   typedef enum logic [1:0] {
      ARM_OFF  = 2'd0,   // idle checking disabled or no operation
      ARM_WAIT = 2'd1,   // idle-detect window still open
      ARM_LIVE = 2'd2    // idle checking in force
   } rxw_arm_e;

endpackage

// File: rtl/rxw_run_det.sv
// Detects a run of RUN consecutive one bits on a strobed bit stream.
module rxw_run_det #(
   parameter int unsigned RUN = 15
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic stb_i,
   input  logic bit_i,
   output logic full_o
);

   if (RUN == 0) begin : g_bad_run
      $error("rxw_run_det: RUN must be at least 1");
   end

   if (RUN <= 8) begin : g_shift
      // Short runs: keep the last RUN bits and AND them
      logic [RUN-1:0] win_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      win_q <= '0;
         else if (clr_i)  win_q <= '0;
         else if (stb_i)  win_q <= (win_q << 1) | RUN'(bit_i);
      end
      assign full_o = &win_q;
   end else begin : g_count
      // Long runs: saturating counter cleared by a zero bit
      localparam int unsigned CW = $clog2(RUN + 1);
      localparam logic [CW-1:0] LIMIT = CW'(RUN);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          cnt_q <= '0;
         else if (clr_i)      cnt_q <= '0;
         else if (stb_i) begin
            if (!bit_i)               cnt_q <= '0;
            else if (cnt_q != LIMIT)  cnt_q <= cnt_q + CW'(1);
         end
      end
      assign full_o = (cnt_q == LIMIT);
   end

endmodule

// File: rtl/rxw_tick_timer.sv
// Down-counter in tick units; expires once on the tick that reaches zero.
module rxw_tick_timer #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] val_i,
   input  logic         run_i,
   input  logic         tick_i,
   input  logic         halt_i,
   output logic         expire_o
);

   if (W == 0 || W > 16) begin : g_bad_w
      $error("rxw_tick_timer: W must be 1..16");
   end

   logic [W-1:0] cnt_q;
   logic         live_q;
   logic         step;

   assign step = live_q & run_i & tick_i & ~halt_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         live_q <= 1'b0;
      end else if (load_i) begin
         cnt_q  <= val_i;
         live_q <= (val_i != '0);
      end else if (halt_i) begin
         live_q <= 1'b0;
      end else if (step) begin
         cnt_q <= cnt_q - W'(1);
         if (cnt_q == W'(1)) live_q <= 1'b0;
      end
   end

   assign expire_o = step & ~load_i & (cnt_q == W'(1));

endmodule

// File: rtl/rx_line_watchdog.sv
module rx_line_watchdog
   import rxw_pkg::*;
#(
   parameter int unsigned TMR_W    = RXW_TMR_W,
   parameter int unsigned IDLE_RUN = RXW_IDLE_RUN
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_start_i,
   input  logic             rx_stop_i,
   input  logic             bit_stb_i,
   input  logic             bit_i,
   input  logic             flag_stb_i,
   input  logic             frame_act_i,
   input  logic             tick_i,
   input  logic [TMR_W-1:0] idle_tmo_i,
   input  logic [TMR_W-1:0] nprod_tmo_i,
   output logic             idle_exc_o,
   output logic             idle_sts_o,
   output logic             nprod_exc_o
);

   if (IDLE_RUN < 2) begin : g_bad_run
      $error("rx_line_watchdog: IDLE_RUN must be at least 2");
   end

   logic     active_q;
   rxw_arm_e arm_q;
   logic     line_idle;
   logic     win_exp;
   logic     nprod_exp;
   logic     idle_hit;
   logic     idle_exc_q, idle_sts_q, nprod_exc_q;

   // Operation window
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         active_q <= 1'b0;
      else if (rx_start_i) active_q <= 1'b1;
      else if (rx_stop_i)  active_q <= 1'b0;
   end

   // Run of ones on the line
   rxw_run_det #(.RUN(IDLE_RUN)) u_run (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (rx_start_i),
      .stb_i  (bit_stb_i),
      .bit_i  (bit_i),
      .full_o (line_idle)
   );

   // Idle-detect window timer
   rxw_tick_timer #(.W(TMR_W)) u_win_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (rx_start_i),
      .val_i    (idle_tmo_i),
      .run_i    (arm_q == ARM_WAIT),
      .tick_i   (tick_i),
      .halt_i   (flag_stb_i | rx_stop_i),
      .expire_o (win_exp)
   );

   // Nonproductive time accumulator
   rxw_tick_timer #(.W(TMR_W)) u_np_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (rx_start_i),
      .val_i    (nprod_tmo_i),
      .run_i    (active_q & ~frame_act_i & ~flag_stb_i),
      .tick_i   (tick_i),
      .halt_i   (rx_stop_i),
      .expire_o (nprod_exp)
   );

   // Idle monitoring phase
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         arm_q <= ARM_OFF;
      end else if (rx_start_i) begin
         arm_q <= (idle_tmo_i != '0) ? ARM_WAIT : ARM_OFF;
      end else if (rx_stop_i) begin
         arm_q <= ARM_OFF;
      end else if (arm_q == ARM_WAIT && (win_exp || flag_stb_i)) begin
         arm_q <= ARM_LIVE;
      end
   end

   assign idle_hit = (arm_q == ARM_LIVE) & line_idle & ~idle_sts_q;

   // Exception registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idle_exc_q  <= 1'b0;
         idle_sts_q  <= 1'b0;
         nprod_exc_q <= 1'b0;
      end else begin
         idle_exc_q  <= idle_hit & ~rx_start_i;
         nprod_exc_q <= nprod_exp;
         if (rx_start_i)    idle_sts_q <= 1'b0;
         else if (idle_hit) idle_sts_q <= 1'b1;
      end
   end

   assign idle_exc_o  = idle_exc_q;
   assign idle_sts_o  = idle_sts_q;
   assign nprod_exc_o = nprod_exc_q;

endmodule

// File: rtl/rxw_checker.sv
module rxw_checker (
   input logic clk,
   input logic rst_n,
   input logic rx_start_i,
   input logic rx_stop_i,
   input logic bit_stb_i,
   input logic bit_i,
   input logic frame_act_i,
   input logic idle_exc_o,
   input logic idle_sts_o,
   input logic nprod_exc_o
);

   AST_IDLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      idle_exc_o |=> !idle_exc_o); // R6

   AST_IDLE_STS_SET: assert property (@(posedge clk) disable iff (!rst_n)
      idle_exc_o |-> idle_sts_o); // R6

   AST_IDLE_STS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (idle_sts_o && !rx_start_i) |=> idle_sts_o); // R10

   AST_NPROD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      nprod_exc_o |=> !nprod_exc_o); // R7

   AST_NPROD_PAUSED: assert property (@(posedge clk) disable iff (!rst_n)
      frame_act_i |=> !nprod_exc_o); // R7

   AST_ZERO_BREAKS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_stb_i && !bit_i) |=> ##1 !idle_exc_o); // R2

   AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_stop_i && !rx_start_i) |=> ##1 (!idle_exc_o && !nprod_exc_o)); // R10

endmodule

bind rx_line_watchdog rxw_checker u_rxw_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .rx_start_i  (rx_start_i),
   .rx_stop_i   (rx_stop_i),
   .bit_stb_i   (bit_stb_i),
   .bit_i       (bit_i),
   .frame_act_i (frame_act_i),
   .idle_exc_o  (idle_exc_o),
   .idle_sts_o  (idle_sts_o),
   .nprod_exc_o (nprod_exc_o)
);

// File: tb/rx_line_watchdog_tb_top.sv
module rx_line_watchdog_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 7;
   // {window ticks, ticks applied, ones sent, expected idle status}
   localparam int unsigned VEC [NVEC][4] = '{
      '{3,   3,   15, 1},
      '{3,   2,   15, 0},
      '{3,   3,   14, 0},
      '{0,   5,   20, 0},
      '{1,   1,   15, 1},
      '{255, 255, 15, 1},
      '{255, 254, 15, 0}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rx_start_i = 0, rx_stop_i = 0, bit_stb_i = 0, bit_i = 0;
   logic flag_stb_i = 0, frame_act_i = 0, tick_i = 0;
   logic [7:0] idle_tmo_i = '0, nprod_tmo_i = '0;
   logic idle_exc_o, idle_sts_o, nprod_exc_o;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rx_line_watchdog dut_i (
      .clk(clk), .rst_n(rst_n), .rx_start_i(rx_start_i), .rx_stop_i(rx_stop_i),
      .bit_stb_i(bit_stb_i), .bit_i(bit_i), .flag_stb_i(flag_stb_i),
      .frame_act_i(frame_act_i), .tick_i(tick_i), .idle_tmo_i(idle_tmo_i),
      .nprod_tmo_i(nprod_tmo_i), .idle_exc_o(idle_exc_o), .idle_sts_o(idle_sts_o),
      .nprod_exc_o(nprod_exc_o)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic do_start(input int t1, input int t2);
      @(negedge clk);
      rx_start_i = 1'b1; idle_tmo_i = 8'(t1); nprod_tmo_i = 8'(t2);
      @(negedge clk);
      rx_start_i = 1'b0;
   endtask

   task automatic do_stop();
      @(negedge clk); rx_stop_i = 1'b1;
      @(negedge clk); rx_stop_i = 1'b0;
   endtask

   task automatic do_tick();
      @(negedge clk); tick_i = 1'b1;
      @(negedge clk); tick_i = 1'b0;
   endtask

   task automatic do_flag();
      @(negedge clk); flag_stb_i = 1'b1;
      @(negedge clk); flag_stb_i = 1'b0;
   endtask

   task automatic do_bit(input logic b);
      @(negedge clk); bit_stb_i = 1'b1; bit_i = b;
      @(negedge clk); bit_stb_i = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1", "idle_exc", idle_exc_o, 0);
      chk("R1", "idle_sts", idle_sts_o, 0);
      chk("R1", "nprod_exc", nprod_exc_o, 0);

      // R3 window vectors (R5 for the zero-window row)
      for (int i = 0; i < NVEC; i++) begin
         do_start(int'(VEC[i][0]), 0);
         repeat (VEC[i][1]) do_tick();
         repeat (VEC[i][2]) do_bit(1'b1);
         @(negedge clk);
         chk(VEC[i][0] == 0 ? "R5" : "R3", $sformatf("vector %0d idle_sts", i),
             idle_sts_o, int'(VEC[i][3]));
      end

      // R4 flag arms at once; R6 pulse width and sticky
      do_start(200, 0);
      do_flag();
      repeat (15) do_bit(1'b1);
      chk("R6", "no exc before latency", idle_exc_o, 0);
      @(negedge clk);
      chk("R4", "idle_exc after flag", idle_exc_o, 1);
      chk("R6", "sts with exc", idle_sts_o, 1);
      @(negedge clk);
      chk("R6", "exc one cycle", idle_exc_o, 0);
      // R6 only once per operation
      do_bit(1'b0);
      repeat (15) do_bit(1'b1);
      @(negedge clk);
      chk("R6", "second idle no exc", idle_exc_o, 0);
      chk("R6", "sts held", idle_sts_o, 1);
      // R10 stop keeps sticky; R9 start clears it
      do_stop();
      chk("R10", "sts after stop", idle_sts_o, 1);
      do_start(0, 0);
      chk("R9", "sts cleared by start", idle_sts_o, 0);

      // R2 zero restarts run
      do_start(9, 0);
      do_flag();
      repeat (14) do_bit(1'b1);
      do_bit(1'b0);
      repeat (14) do_bit(1'b1);
      @(negedge clk);
      chk("R2", "14 after zero", idle_sts_o, 0);
      do_bit(1'b1);
      @(negedge clk);
      chk("R2", "15 after zero", idle_exc_o, 1);

      // R2 saturation: long run before arming, then window closes
      do_start(2, 0);
      repeat (20) do_bit(1'b1);
      @(negedge clk);
      chk("R3", "idle before window end", idle_sts_o, 0);
      do_tick();
      do_tick();
      @(negedge clk);
      chk("R2", "saturated run idle", idle_exc_o, 1);

      // R5 zero window ignores flags
      do_start(0, 0);
      do_flag();
      repeat (20) do_bit(1'b1);
      repeat (5) do_tick();
      @(negedge clk);
      chk("R5", "zero window idle_sts", idle_sts_o, 0);

      // R7 basic expiry
      do_start(0, 3);
      do_tick(); chk("R7", "tick1", nprod_exc_o, 0);
      do_tick(); chk("R7", "tick2", nprod_exc_o, 0);
      do_tick(); chk("R7", "tick3", nprod_exc_o, 1);
      @(negedge clk);
      chk("R7", "one cycle", nprod_exc_o, 0);
      begin
         int seen = 0;
         for (int k = 0; k < 4; k++) begin do_tick(); seen += int'(nprod_exc_o); end
         chk("R7", "once per operation", seen, 0);
      end

      // R7 pause and resume
      do_start(0, 3);
      frame_act_i = 1'b1;
      begin
         int seen = 0;
         for (int k = 0; k < 5; k++) begin do_tick(); seen += int'(nprod_exc_o); end
         chk("R7", "paused by frame", seen, 0);
      end
      frame_act_i = 1'b0;
      do_tick(); do_tick();
      chk("R7", "two counted", nprod_exc_o, 0);
      do_tick();
      chk("R7", "accumulated expiry", nprod_exc_o, 1);

      // R7 flag coinciding with tick pauses it
      do_start(0, 2);
      do_tick();
      @(negedge clk); tick_i = 1'b1; flag_stb_i = 1'b1;
      @(negedge clk); tick_i = 1'b0; flag_stb_i = 1'b0;
      chk("R7", "flag tick not counted", nprod_exc_o, 0);
      do_tick();
      chk("R7", "expiry after flag", nprod_exc_o, 1);

      // R8 zero disables
      do_start(0, 0);
      begin
         int seen = 0;
         for (int k = 0; k < 300; k++) begin do_tick(); seen += int'(nprod_exc_o); end
         chk("R8", "zero limit", seen, 0);
      end

      // R9 chained start reloads
      do_start(0, 5);
      repeat (3) do_tick();
      do_start(0, 2);
      do_tick(); chk("R9", "reload tick1", nprod_exc_o, 0);
      do_tick(); chk("R9", "reload tick2", nprod_exc_o, 1);

      // R10 stop silences both
      do_start(5, 2);
      do_stop();
      begin
         int seen = 0;
         for (int k = 0; k < 6; k++) begin do_tick(); seen += int'(nprod_exc_o); end
         chk("R10", "nprod after stop", seen, 0);
      end
      do_flag();
      repeat (15) do_bit(1'b1);
      @(negedge clk);
      chk("R10", "idle after stop", idle_sts_o, 0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule